// File: doc/BRIEF.md
# Clock Generator Power-State Controller

This block decides, cycle by cycle, which frequency sources of a multi-source clock generator may run and which clock outputs may drive their pads. Two asynchronous pins steer it: an active-low output-enable pin that can also power the generator down, and an active-low suspend pin that doubles as the top bit of the CPU frequency select. A static configuration image, captured while reset is held, says whether the enable pin stops the sources, whether the suspend function exists, which sources and outputs suspend removes, and which source feeds each output. The always-on 32.768 kHz output is not switched here, so it has no port.

The pins pass through two synchronising flip-flops. A four-state machine then follows them: ST_RUN (everything on), ST_SUSP (masked sources stopped, masked outputs off), ST_HIZ (outputs off, sources running) and ST_SHDN (outputs off, all sources and the reference oscillator stopped). The transitions are T_OE_DROP_HIZ and T_OE_DROP_FULL (enable pin falls, into ST_HIZ or ST_SHDN by the configuration), T_SUSP_ENTER (into ST_SUSP), T_SUSP_LEAVE (ST_SUSP back to ST_RUN) and T_WAKE (from ST_HIZ or ST_SHDN to ST_RUN or ST_SUSP). Each source has a lock-wait counter, counted in control clock cycles. The counter reloads while its source is stopped. After a restart it raises a re-lock request and keeps the dependent outputs off until it expires.

Top module: `clkpwr_ctl`

## Requirements
- R1: Three cycles after the enable pin goes low, every bit of out_en is 0, whatever the configuration and the suspend pin.
- R2: With full_stop = 1, the enable pin held low gives src_run = 4'b0000. With full_stop = 0, it leaves src_run = 4'b1111. The bits of src_run are 0 reference oscillator, 1 CPU, 2 utility, 3 system.
- R3: With susp_opt = 1, the enable pin high and the suspend pin low, each source whose src_susp bit is set is stopped (src_susp bit 0 CPU, bit 1 utility, bit 2 system), and each output whose out_susp bit is set has out_en = 0. The reference oscillator is never suspended.
- R4: An output is enabled only while the source chosen by its 2-bit out_src field is running and not waiting for lock (0 reference, 1 CPU, 2 utility, 3 system), whatever its own mask bit says.
- R5: With susp_opt = 0, the suspend pin has no effect on src_run or out_en.
- R6: After a source restarts, relock_req for that source stays 1 and its outputs stay off. The wait lasts REF_LOCK_CYC, CPU_LOCK_CYC or AUX_LOCK_CYC cycles, so a dependent output first shows 1 three cycles plus the lock count after the pin edge that restarted the source.
- R7: cpu_sel equals {suspend pin, sel_lo_pin[1:0]} two cycles after the pins change, whether or not the suspend option is configured.
- R8: While rst_n is low, the configuration image is captured, src_run = 4'b1111, relock_req = 4'b1111 and out_en = 0. The lock counters then run from full count after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running control clock at the reference rate |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_image | input | CFG_W | Packed configuration image (pwr_cfg_t) |
| oe_pin_n | input | 1 | Asynchronous output-enable / power-down pin, active low |
| susp_pin_n | input | 1 | Asynchronous suspend pin, active low; also CPU select MSB |
| sel_lo_pin | input | 2 | Asynchronous CPU select low bits |
| src_run | output | NUM_SRC | Run (1) / stop (0) per source |
| relock_req | output | NUM_SRC | Source running but lock wait not yet over |
| out_en | output | NUM_OUT | Pad drive enable per clock output; 0 means three-state |
| cpu_sel | output | 3 | Synchronised CPU frequency select |

## Verification
The bench targets the dependency rule. An output whose own mask bit is clear must still drop when its source is suspended, and a design that gated only on the mask would leave it toggling with a dead source. It times the lock release of each source from power-down separately. A shared or miswired counter would release the CPU outputs after the short utility wait, and a counter that failed to reload would release them at once. It also checks that the suspend pin is ignored without the option but still reaches cpu_sel, and that the enable pin's power-down choice follows the configuration bit.

// File: rtl/clkpwr_pkg.sv
package clkpwr_pkg;
    parameter int NUM_OUT = 7;
    parameter int NUM_SRC = 4;
    localparam int SRC_IW = $clog2(NUM_SRC);
    localparam int SRC_REF = 0;
    localparam int SRC_CPU = 1;

    typedef struct packed {
        logic                             full_stop;
        logic                             susp_opt;
        logic [NUM_SRC-2:0]               src_susp;
        logic [NUM_OUT-1:0]               out_susp;
        logic [NUM_OUT-1:0][SRC_IW-1:0]   out_src;
    } pwr_cfg_t;

    localparam int CFG_W = $bits(pwr_cfg_t);

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_SUSP = 2'd1,
        ST_HIZ  = 2'd2,
        ST_SHDN = 2'd3
    } pwr_state_e;
endpackage

// File: rtl/clkpwr_sync.sv
module clkpwr_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            dout   <= RST_VAL;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end
endmodule

// File: rtl/clkpwr_lock.sv
module clkpwr_lock #(
    parameter int LOCK_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic ready,
    output logic waiting
);
    localparam int CW = $clog2(LOCK_CYC + 2);
    localparam logic [CW-1:0] LOAD = CW'(LOCK_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign ready   = run && (cnt == '0);
    assign waiting = run && (cnt != '0);
endmodule

// File: rtl/clkpwr_ctl.sv
module clkpwr_ctl
    import clkpwr_pkg::*;
#(
    parameter int CPU_LOCK_CYC = 715909,
    parameter int AUX_LOCK_CYC = 14319,
    parameter int REF_LOCK_CYC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CFG_W-1:0]   cfg_image,
    input  logic               oe_pin_n,
    input  logic               susp_pin_n,
    input  logic [1:0]         sel_lo_pin,
    output logic [NUM_SRC-1:0] src_run,
    output logic [NUM_SRC-1:0] relock_req,
    output logic [NUM_OUT-1:0] out_en,
    output logic [2:0]         cpu_sel
);
    pwr_cfg_t     cfg_q;
    pwr_state_e   state, state_nx;
    logic         oe_s, susp_s;
    logic [1:0]   sel_s;
    logic         susp_act;
    logic         out_gate, mask_gate;
    logic [NUM_SRC-1:0] src_ready;

    // configuration image is held for as long as reset is asserted
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= pwr_cfg_t'(cfg_image);
    end

    clkpwr_sync #(.W(4), .RST_VAL(4'b1100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({oe_pin_n, susp_pin_n, sel_lo_pin}),
        .dout ({oe_s, susp_s, sel_s})
    );

    assign cpu_sel  = {susp_s, sel_s};
    assign susp_act = cfg_q.susp_opt && !susp_s;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (!oe_s)         state_nx = cfg_q.full_stop ? ST_SHDN : ST_HIZ; // T_OE_DROP_*
                else if (susp_act) state_nx = ST_SUSP;                            // T_SUSP_ENTER
            end
            ST_SUSP: begin
                if (!oe_s)          state_nx = cfg_q.full_stop ? ST_SHDN : ST_HIZ; // T_OE_DROP_*
                else if (!susp_act) state_nx = ST_RUN;                             // T_SUSP_LEAVE
            end
            ST_HIZ, ST_SHDN: begin
                if (oe_s) state_nx = susp_act ? ST_SUSP : ST_RUN;                  // T_WAKE
            end
            default: state_nx = ST_RUN;
        endcase
    end

    // state outputs
    always_comb begin
        src_run   = '1;
        out_gate  = 1'b0;
        mask_gate = 1'b0;
        unique case (state)
            ST_RUN: begin
                out_gate = 1'b1;
            end
            ST_SUSP: begin
                src_run   = {~cfg_q.src_susp, 1'b1};
                out_gate  = 1'b1;
                mask_gate = 1'b1;
            end
            ST_HIZ: begin
                src_run = '1;
            end
            ST_SHDN: begin
                src_run = '0;
            end
            default: src_run = '1;
        endcase
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_lock
        localparam int LK = (s == SRC_REF) ? REF_LOCK_CYC :
                            (s == SRC_CPU) ? CPU_LOCK_CYC : AUX_LOCK_CYC;
        clkpwr_lock #(.LOCK_CYC(LK)) u_lock (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (src_run[s]),
            .ready  (src_ready[s]),
            .waiting(relock_req[s])
        );
    end

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        assign out_en[o] = out_gate
                         && !(mask_gate && cfg_q.out_susp[o])
                         && src_ready[cfg_q.out_src[o]];
    end
endmodule

// File: rtl/clkpwr_chk.sv
module clkpwr_chk
    import clkpwr_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               oe_s,
    input logic               susp_s,
    input pwr_cfg_t           cfg,
    input logic [NUM_SRC-1:0] src_run,
    input logic [NUM_SRC-1:0] relock_req,
    input logic [NUM_OUT-1:0] out_en
);
    AST_OE_LOW_OUTS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_s |=> out_en == '0); // R1

    AST_FULL_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_s && cfg.full_stop) |=> src_run == '0); // R2

    AST_OE_ONLY_KEEPS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_s && !cfg.full_stop) |=> src_run == '1); // R2

    AST_SUSP_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_s && !susp_s && cfg.susp_opt) |=>
        ((src_run[NUM_SRC-1:1] & cfg.src_susp) == '0 && (out_en & cfg.out_susp) == '0)); // R3

    AST_NO_OPT_NO_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_s && !cfg.susp_opt) |=> src_run == '1); // R5

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src_chk
        AST_RELOCK_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
            relock_req[s] |-> src_run[s]); // R6
    end

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out_chk
        AST_OUT_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
            out_en[o] |-> (src_run[cfg.out_src[o]] && !relock_req[cfg.out_src[o]])); // R4
    end
endmodule

bind clkpwr_ctl clkpwr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .oe_s      (oe_s),
    .susp_s    (susp_s),
    .cfg       (cfg_q),
    .src_run   (src_run),
    .relock_req(relock_req),
    .out_en    (out_en)
);

// File: tb/clkpwr_ctl_test.sv
module clkpwr_ctl_test;
    import clkpwr_pkg::*;

    localparam int CPU_L = 20;
    localparam int AUX_L = 6;
    localparam int REF_L = 3;
    localparam logic [13:0] OUT_MAP = 14'b00_11_01_11_10_00_01;
    localparam int SRC_OF [NUM_OUT] = '{1, 0, 2, 3, 1, 3, 0};

    // {full, opt, src_mask[2:0], out_mask[6:0], oe, susp, exp_src[3:0]}
    localparam logic [17:0] VECS [8] = '{
        {1'b1, 1'b1, 3'b000, 7'b0000000, 1'b1, 1'b1, 4'b1111},
        {1'b1, 1'b1, 3'b001, 7'b0000000, 1'b1, 1'b0, 4'b1101},
        {1'b1, 1'b1, 3'b110, 7'b0000001, 1'b1, 1'b0, 4'b0011},
        {1'b1, 1'b0, 3'b111, 7'b1111111, 1'b1, 1'b0, 4'b1111},
        {1'b1, 1'b1, 3'b111, 7'b0000000, 1'b0, 1'b0, 4'b0000},
        {1'b0, 1'b1, 3'b111, 7'b0000000, 1'b0, 1'b1, 4'b1111},
        {1'b0, 1'b1, 3'b010, 7'b1000000, 1'b1, 1'b0, 4'b1011},
        {1'b1, 1'b1, 3'b000, 7'b1111111, 1'b1, 1'b1, 4'b1111}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    pwr_cfg_t cfg;
    logic oe_n = 1'b1, susp_n = 1'b1;
    logic [1:0] sel_lo = 2'b00;
    logic [NUM_SRC-1:0] src_run, relock_req;
    logic [NUM_OUT-1:0] out_en;
    logic [2:0] cpu_sel;
    int n_tests = 0, n_fail = 0;

    always #10 clk = ~clk;

    clkpwr_ctl #(.CPU_LOCK_CYC(CPU_L), .AUX_LOCK_CYC(AUX_L), .REF_LOCK_CYC(REF_L)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_image(cfg), .oe_pin_n(oe_n), .susp_pin_n(susp_n),
        .sel_lo_pin(sel_lo), .src_run(src_run), .relock_req(relock_req),
        .out_en(out_en), .cpu_sel(cpu_sel)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic full, input logic opt, input logic [2:0] sm,
                           input logic [6:0] om);
        cfg.full_stop = full;
        cfg.susp_opt  = opt;
        cfg.src_susp  = sm;
        cfg.out_susp  = om;
        cfg.out_src   = OUT_MAP;
    endtask

    task automatic do_reset(input logic oe, input logic sp);
        rst_n = 1'b0;
        oe_n = oe;
        susp_n = sp;
        step(3);
        rst_n = 1'b1;
    endtask

    function automatic logic [NUM_OUT-1:0] model(input logic opt, input logic [6:0] om,
                                                  input logic oe, input logic sp,
                                                  input logic [3:0] es);
        logic [NUM_OUT-1:0] r = '0;
        if (!oe) return r;
        for (int o = 0; o < NUM_OUT; o++)
            r[o] = es[SRC_OF[o]] && !(opt && !sp && om[o]);
        return r;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int t_ref, t_util, t_cpu;
        set_cfg(1'b1, 1'b0, 3'b000, 7'b0);

        // R8: reset state
        rst_n = 1'b0;
        step(3);
        check("R8 src_run in reset", 32'(src_run), 32'hF);
        check("R8 relock in reset", 32'(relock_req), 32'hF);
        check("R8 out_en in reset", 32'(out_en), 32'h0);
        rst_n = 1'b1;
        step(1);
        check("R8 outputs wait after reset", 32'(out_en), 32'h0);

        // table walk: R2 R3 R4 R5
        for (int i = 0; i < 8; i++) begin
            logic [17:0] v = VECS[i];
            set_cfg(v[17], v[16], v[15:13], v[12:6]);
            do_reset(v[5], v[4]);
            step(40);
            check($sformatf("R2/R3/R5 src_run vec %0d", i), 32'(src_run), 32'(v[3:0]));
            check($sformatf("R3/R4 out_en vec %0d", i), 32'(out_en),
                  32'(model(v[16], v[12:6], v[5], v[4], v[3:0])));
            check($sformatf("R6 relock idle vec %0d", i), 32'(relock_req), 32'h0);
        end

        // R1: output-only drop, latency of three cycles
        set_cfg(1'b0, 1'b1, 3'b111, 7'b0);
        do_reset(1'b1, 1'b1);
        step(40);
        check("R1 outputs on before drop", 32'(out_en), 32'h7F);
        oe_n = 1'b0;
        step(2);
        check("R1 outputs still on at two cycles", 32'(out_en), 32'h7F);
        step(1);
        check("R1 outputs off at three cycles", 32'(out_en), 32'h0);
        check("R2 sources kept with output-only option", 32'(src_run), 32'hF);

        // R6: lock release per source after full power-down
        set_cfg(1'b1, 1'b0, 3'b000, 7'b0);
        do_reset(1'b1, 1'b1);
        step(40);
        oe_n = 1'b0;
        step(10);
        check("R2 full stop", 32'(src_run), 32'h0);
        oe_n = 1'b1;
        t_ref = 0; t_util = 0; t_cpu = 0;
        for (int k = 1; k <= 40; k++) begin
            step(1);
            if (k == 4) check("R6 relock after restart", 32'(relock_req), 32'hF);
            if (t_ref == 0 && out_en[1]) t_ref = k;
            if (t_util == 0 && out_en[2]) t_util = k;
            if (t_cpu == 0 && out_en[0]) t_cpu = k;
        end
        check("R6 reference release cycle", 32'(t_ref), 32'(3 + REF_L));
        check("R6 utility release cycle", 32'(t_util), 32'(3 + AUX_L));
        check("R6 cpu release cycle", 32'(t_cpu), 32'(3 + CPU_L));

        // R7: select bits, suspend pin as MSB even without the option
        sel_lo = 2'b01;
        susp_n = 1'b0;
        step(2);
        check("R7 cpu_sel low msb", 32'(cpu_sel), 32'h1);
        check("R5 pin ignored without option", 32'(out_en), 32'h7F);
        sel_lo = 2'b10;
        susp_n = 1'b1;
        step(2);
        check("R7 cpu_sel high msb", 32'(cpu_sel), 32'h6);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule